// File: doc/BRIEF.md
# Predicated Vector Element-Loop Sequencer

This block expands one prefixed scalar operation into a stream of per-element issue records, one per clock. When a loop is launched it captures a vector length, a base register number for the source and for the destination (each marked scalar or vector), a predicate mask for each side, an element-width override, a direction flag and a carry-chain enable. While the loop runs it emits, each cycle, the register numbers and byte offsets of one source element and one destination element, together with the carry-in for that element.

The source mask and the destination mask skip elements independently: the k-th issue pairs the k-th enabled source element with the k-th enabled destination element. Each mask comes from an integer register, from its complement, from one chosen bit of each condition field, or is all ones. Narrow elements are packed into 64-bit registers, so an operand's register number advances once per group of elements and the byte offset names the lane. A reverse mode walks the elements from the top index down. A start/busy/done handshake frames every loop; the arithmetic itself, the register storage and the decode lie outside.

Top module: `elem_loop_seq`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures every loop input and raises `busy` in the next cycle; a `start` seen while `busy` is high (including the cycle in which `done` is high) has no effect on the running loop or on what follows it.
- R2: With a vector length of zero, `done` is high in the cycle after `start` and no issue record is produced.
- R3: The effective length is the `vl` input capped at 64; in forward mode the loop issues at most that many records, one per cycle from the cycle after `start`, element indices ascending, and `done` follows in the cycle after the last issue.
- R4: The source and destination masks act independently: issue k uses the k-th enabled source index and the k-th enabled destination index, and the loop ends as soon as either side has no enabled index left below the length.
- R5: Predicate select codes are 0 = all elements enabled, 1 = bit i of the integer mask, 2 = bit `cr_bit_sel` of condition field i (field i is `cr_fields[4i+3:4i]`), 3 = complement of bit i of the integer mask.
- R6: With `reverse` high the element indices run from length-1 down to 0, with each mask skipping in that direction.
- R7: Element-width code `elw` 0/1/2/3 selects 64/32/16/8-bit elements; a vector operand's register number is base + (index >> elw) and its byte offset is (index mod 2^elw) × (8 >> elw).
- R8: A scalar operand keeps its base register number and a byte offset of 0 on every issue.
- R9: If a vector operand's register number for the next element would exceed 127, that element is not issued and the loop ends with `done`.
- R10: The first issue of a loop carries `carry_init`; with chaining enabled each later issue carries the `alu_carry_out` value present during the previous issue, and with chaining disabled every issue carries `carry_init`.
- R11: `done` is high for exactly one cycle, never in the same cycle as `issue_valid`, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| vl | input | 7 | Requested vector length |
| src_base | input | 7 | Source base register number |
| src_is_vec | input | 1 | Source is a vector operand |
| dst_base | input | 7 | Destination base register number |
| dst_is_vec | input | 1 | Destination is a vector operand |
| src_pred_sel | input | 2 | Source predicate select code |
| dst_pred_sel | input | 2 | Destination predicate select code |
| src_gpr_mask | input | 64 | Integer mask value for the source side |
| dst_gpr_mask | input | 64 | Integer mask value for the destination side |
| cr_fields | input | 256 | 64 four-bit condition fields |
| cr_bit_sel | input | 2 | Bit chosen from each condition field |
| elw | input | 2 | Element-width code |
| reverse | input | 1 | Run elements from the top down |
| chain_en | input | 1 | Enable carry chaining between elements |
| carry_init | input | 1 | Carry-in for the first element |
| alu_carry_out | input | 1 | Carry produced by the element being issued |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle end-of-loop marker |
| issue_valid | output | 1 | Issue record valid this cycle |
| issue_src_reg | output | 7 | Source register number |
| issue_src_off | output | 3 | Source byte offset |
| issue_dst_reg | output | 7 | Destination register number |
| issue_dst_off | output | 3 | Destination byte offset |
| issue_chain_en | output | 1 | Carry chaining active for this loop |
| issue_carry_in | output | 1 | Carry-in for this element |

## Verification
The loop's end and a fresh launch request can meet in one cycle: the bench raises `start` with different settings exactly in the cycle where `done` is high, while `busy` is still set. It then judges that `busy` is low in the next cycle and that no stray issue record follows. A second collision, a start pulse in the middle of a running loop, is judged by the issue stream still matching the model of the original loop record for record. The cycle count from launch to `done` is compared with the number of expected issues plus one.

// File: rtl/elem_loop_pkg.sv
// Package: shared encodings for the element-loop sequencer.
// Assumes: 2-bit element-width and predicate-select codes.
package elem_loop_pkg;

    typedef enum logic [1:0] {
        EW_64 = 2'd0,
        EW_32 = 2'd1,
        EW_16 = 2'd2,
        EW_8  = 2'd3
    } elw_e;

    typedef enum logic [1:0] {
        PS_ALL    = 2'd0,
        PS_GPR    = 2'd1,
        PS_CRBIT  = 2'd2,
        PS_GPRINV = 2'd3
    } pred_sel_e;

    localparam int BYTE_OFF_W = 3;

endpackage

// File: rtl/pred_assemble.sv
// pred_assemble: builds an N-bit element mask from one of four sources.
// Assumes: condition field i occupies bits [CR_W*i +: CR_W] of cr.
module pred_assemble #(
    parameter int N    = 64,
    parameter int CR_W = 4
) (
    input  logic [1:0]        sel,
    input  logic [N-1:0]      gpr,
    input  logic [N*CR_W-1:0] cr,
    input  logic [1:0]        cr_bit,
    output logic [N-1:0]      mask
);
    import elem_loop_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CR_W-1:0] field;
        assign field = cr[i*CR_W +: CR_W];
        // Pick the mask bit for element i according to the select code.
        always_comb begin
            case (pred_sel_e'(sel))
                PS_ALL:    mask[i] = 1'b1;
                PS_GPR:    mask[i] = gpr[i];
                PS_CRBIT:  mask[i] = field[cr_bit];
                default:   mask[i] = ~gpr[i];
            endcase
        end
    end

endmodule

// File: rtl/elem_scan.sv
// elem_scan: finds the next enabled element at or beyond a cursor.
// Forward: lowest set bit with cursor <= i < vl. Reverse: highest set
// bit with i <= cursor and i < vl. Assumes cursor is signed (may be -1).
module elem_scan #(
    parameter int N  = 64,
    parameter int CW = 8
) (
    input  logic [N-1:0]         mask,
    input  logic signed [CW-1:0] cur,
    input  logic [CW-1:0]        vl,
    input  logic                 rev,
    output logic                 found,
    output logic [CW-1:0]        idx
);
    // Priority search in the requested direction.
    always_comb begin
        int ci;
        int vi;
        ci    = int'(cur);
        vi    = int'(vl);
        found = 1'b0;
        idx   = '0;
        if (!rev) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (mask[i] && i < vi && i >= ci) begin
                    found = 1'b1;
                    idx   = CW'(i);
                end
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (mask[i] && i < vi && i <= ci) begin
                    found = 1'b1;
                    idx   = CW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/operand_addr.sv
// operand_addr: maps an element index to register number and byte lane.
// Assumes: elw code k means 2^k elements per 64-bit register.
module operand_addr #(
    parameter int REG_W = 7,
    parameter int CW    = 8
) (
    input  logic [REG_W-1:0] base,
    input  logic             is_vec,
    input  logic [CW-1:0]    idx,
    input  logic [1:0]       elw,
    output logic [REG_W-1:0] regn,
    output logic [2:0]       off,
    output logic             ovf
);
    logic [REG_W:0] sum;
    logic [CW-1:0]  lane;

    // Register number, byte offset and range overflow for one operand.
    always_comb begin
        sum  = {1'b0, base} + (REG_W+1)'(idx >> elw);
        lane = idx & ((CW'(1) << elw) - CW'(1));
        if (is_vec) begin
            regn = sum[REG_W-1:0];
            off  = 3'(lane << (2'd3 - elw));
            ovf  = sum[REG_W];
        end else begin
            regn = base;
            off  = 3'd0;
            ovf  = 1'b0;
        end
    end

endmodule

// File: rtl/elem_loop_seq.sv
// elem_loop_seq: turns one prefixed operation into per-element issues.
// Captures all loop settings on an idle start, then issues one record
// per cycle until a mask side is exhausted or a register would pass the
// top of the file; done is high for one cycle at the end.
// Assumes: synchronous active-low reset; alu_carry_out is valid in the
// cycle of the issue it belongs to.
module elem_loop_seq #(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    parameter int CR_W   = 4,
    localparam int VL_W  = $clog2(MAX_VL) + 1,
    localparam int CW    = $clog2(MAX_VL) + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [VL_W-1:0]        vl,
    input  logic [REG_W-1:0]       src_base,
    input  logic                   src_is_vec,
    input  logic [REG_W-1:0]       dst_base,
    input  logic                   dst_is_vec,
    input  logic [1:0]             src_pred_sel,
    input  logic [1:0]             dst_pred_sel,
    input  logic [MAX_VL-1:0]      src_gpr_mask,
    input  logic [MAX_VL-1:0]      dst_gpr_mask,
    input  logic [MAX_VL*CR_W-1:0] cr_fields,
    input  logic [1:0]             cr_bit_sel,
    input  logic [1:0]             elw,
    input  logic                   reverse,
    input  logic                   chain_en,
    input  logic                   carry_init,
    input  logic                   alu_carry_out,
    output logic                   busy,
    output logic                   done,
    output logic                   issue_valid,
    output logic [REG_W-1:0]       issue_src_reg,
    output logic [2:0]             issue_src_off,
    output logic [REG_W-1:0]       issue_dst_reg,
    output logic [2:0]             issue_dst_off,
    output logic                   issue_chain_en,
    output logic                   issue_carry_in
);
    logic [MAX_VL-1:0]      src_mask_in, dst_mask_in;
    logic [MAX_VL-1:0]      src_mask_q, dst_mask_q;
    logic [CW-1:0]          vl_eff, vl_q;
    logic [REG_W-1:0]       src_base_q, dst_base_q;
    logic                   src_vec_q, dst_vec_q;
    logic [1:0]             elw_q;
    logic                   rev_q, chain_q, carry_q, busy_q;
    logic signed [CW-1:0]   s_cur, d_cur;
    logic                   s_found, d_found, s_ovf, d_ovf, go;
    logic [CW-1:0]          s_idx, d_idx;

    pred_assemble #(.N(MAX_VL), .CR_W(CR_W)) u_src_pred (
        .sel(src_pred_sel), .gpr(src_gpr_mask), .cr(cr_fields),
        .cr_bit(cr_bit_sel), .mask(src_mask_in)
    );
    pred_assemble #(.N(MAX_VL), .CR_W(CR_W)) u_dst_pred (
        .sel(dst_pred_sel), .gpr(dst_gpr_mask), .cr(cr_fields),
        .cr_bit(cr_bit_sel), .mask(dst_mask_in)
    );

    // Cap the requested length at the largest supported element count.
    assign vl_eff = (CW'(vl) > CW'(MAX_VL)) ? CW'(MAX_VL) : CW'(vl);

    elem_scan #(.N(MAX_VL), .CW(CW)) u_src_scan (
        .mask(src_mask_q), .cur(s_cur), .vl(vl_q), .rev(rev_q),
        .found(s_found), .idx(s_idx)
    );
    elem_scan #(.N(MAX_VL), .CW(CW)) u_dst_scan (
        .mask(dst_mask_q), .cur(d_cur), .vl(vl_q), .rev(rev_q),
        .found(d_found), .idx(d_idx)
    );

    operand_addr #(.REG_W(REG_W), .CW(CW)) u_src_addr (
        .base(src_base_q), .is_vec(src_vec_q), .idx(s_idx), .elw(elw_q),
        .regn(issue_src_reg), .off(issue_src_off), .ovf(s_ovf)
    );
    operand_addr #(.REG_W(REG_W), .CW(CW)) u_dst_addr (
        .base(dst_base_q), .is_vec(dst_vec_q), .idx(d_idx), .elw(elw_q),
        .regn(issue_dst_reg), .off(issue_dst_off), .ovf(d_ovf)
    );

    // An element pair may issue only if both sides found one in range.
    assign go             = s_found && d_found && !s_ovf && !d_ovf;
    assign busy           = busy_q;
    assign issue_valid    = busy_q && go;
    assign done           = busy_q && !go;
    assign issue_chain_en = chain_q;
    assign issue_carry_in = carry_q;

    // Loop control: launch when idle, advance cursors, retire on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            vl_q       <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            src_vec_q  <= 1'b0;
            dst_vec_q  <= 1'b0;
            elw_q      <= 2'd0;
            rev_q      <= 1'b0;
            chain_q    <= 1'b0;
            carry_q    <= 1'b0;
            src_mask_q <= '0;
            dst_mask_q <= '0;
            s_cur      <= '0;
            d_cur      <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q     <= 1'b1;
                vl_q       <= vl_eff;
                src_base_q <= src_base;
                dst_base_q <= dst_base;
                src_vec_q  <= src_is_vec;
                dst_vec_q  <= dst_is_vec;
                elw_q      <= elw;
                rev_q      <= reverse;
                chain_q    <= chain_en;
                carry_q    <= carry_init;
                src_mask_q <= src_mask_in;
                dst_mask_q <= dst_mask_in;
                s_cur      <= reverse ? $signed(vl_eff - CW'(1)) : '0;
                d_cur      <= reverse ? $signed(vl_eff - CW'(1)) : '0;
            end
        end else if (go) begin
            s_cur <= rev_q ? $signed(s_idx - CW'(1)) : $signed(s_idx + CW'(1));
            d_cur <= rev_q ? $signed(d_idx - CW'(1)) : $signed(d_idx + CW'(1));
            if (chain_q) carry_q <= alu_carry_out;
        end else begin
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/elem_loop_seq_chk.sv
// elem_loop_seq_chk: temporal checks on the sequencer's handshake and
// carry chain. Assumes it is bound into elem_loop_seq.
module elem_loop_seq_chk #(
    parameter int REG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             issue_valid,
    input logic [REG_W-1:0] issue_src_reg,
    input logic [REG_W-1:0] issue_dst_reg,
    input logic             issue_chain_en,
    input logic             issue_carry_in,
    input logic             alu_carry_out,
    input logic             src_vec_q,
    input logic             dst_vec_q
);
    assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !issue_valid && !done);

    assert_done_retires_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    assert_scalar_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) && !src_vec_q
        |-> issue_src_reg == $past(issue_src_reg));

    assert_scalar_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) && !dst_vec_q
        |-> issue_dst_reg == $past(issue_dst_reg));

    assert_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) && issue_chain_en
        |-> issue_carry_in == $past(alu_carry_out));

    assert_nochain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) && !issue_chain_en
        |-> $stable(issue_carry_in));

endmodule

bind elem_loop_seq elem_loop_seq_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .issue_valid(issue_valid), .issue_src_reg(issue_src_reg),
    .issue_dst_reg(issue_dst_reg), .issue_chain_en(issue_chain_en),
    .issue_carry_in(issue_carry_in), .alu_carry_out(alu_carry_out),
    .src_vec_q(src_vec_q), .dst_vec_q(dst_vec_q)
);

// File: tb/tb_elem_loop_seq.sv
module tb_elem_loop_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   vl = '0;
    logic [6:0]   src_base = '0, dst_base = '0;
    logic         src_is_vec = 1'b0, dst_is_vec = 1'b0;
    logic [1:0]   src_pred_sel = '0, dst_pred_sel = '0;
    logic [63:0]  src_gpr_mask = '0, dst_gpr_mask = '0;
    logic [255:0] cr_fields = '0;
    logic [1:0]   cr_bit_sel = '0, elw = '0;
    logic         reverse = 1'b0, chain_en = 1'b0, carry_init = 1'b0;
    logic         alu_carry_out = 1'b0;
    logic         busy, done, issue_valid, issue_chain_en, issue_carry_in;
    logic [6:0]   issue_src_reg, issue_dst_reg;
    logic [2:0]   issue_src_off, issue_dst_off;

    typedef struct {
        logic [6:0] sr; logic [2:0] so;
        logic [6:0] dr; logic [2:0] dof;
        logic       c;
    } exp_t;

    exp_t        q[$];
    int          errors = 0;
    int          checks = 0;
    int          kk = 0;
    logic [63:0] cur_pat = '0;
    string       cur_tag = "";

    always #4 clk = ~clk;

    elem_loop_seq dut (.*);

    // Monitor: compare each issue record against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected issue src=%0d dst=%0d, expected none",
                         cur_tag, issue_src_reg, issue_dst_reg);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (issue_src_reg !== e.sr || issue_src_off !== e.so ||
                    issue_dst_reg !== e.dr || issue_dst_off !== e.dof ||
                    issue_carry_in !== e.c) begin
                    errors++;
                    $display("FAIL %s: issue got %0d/%0d %0d/%0d c%0d, expected %0d/%0d %0d/%0d c%0d",
                             cur_tag, issue_src_reg, issue_src_off, issue_dst_reg,
                             issue_dst_off, issue_carry_in, e.sr, e.so, e.dr, e.dof, e.c);
                end
            end
            alu_carry_out = cur_pat[kk % 64];
            kk++;
        end
    end

    task automatic check(input string tag, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, expv);
        end
    endtask

    function automatic bit pbit(input logic [1:0] sel, input logic [63:0] m, input int i);
        case (sel)
            2'd0: return 1'b1;
            2'd1: return m[i];
            2'd2: return cr_fields[4*i + int'(cr_bit_sel)];
            default: return ~m[i];
        endcase
    endfunction

    // Driver: model the loop, fill the scoreboard, run and judge the ending.
    task automatic run_case(input string tag, input int n_vl,
                            input int sb, input bit sv, input int db, input bit dv,
                            input logic [1:0] ss, input logic [1:0] ds,
                            input logic [63:0] sm, input logic [63:0] dm,
                            input int ew, input bit rev, input bit ch, input bit ci,
                            input logic [63:0] pat, input bit poke_mid);
        int sl[$];
        int dl[$];
        int vle, n, cyc;
        vle = (n_vl > 64) ? 64 : n_vl;
        cur_tag = tag;
        cur_pat = pat;
        kk = 0;
        @(negedge clk);
        vl = 7'(n_vl); src_base = 7'(sb); src_is_vec = sv; dst_base = 7'(db);
        dst_is_vec = dv; src_pred_sel = ss; dst_pred_sel = ds;
        src_gpr_mask = sm; dst_gpr_mask = dm; elw = 2'(ew); reverse = rev;
        chain_en = ch; carry_init = ci;
        for (int j = 0; j < vle; j++) begin
            int i;
            i = rev ? (vle - 1 - j) : j;
            if (pbit(ss, sm, i)) sl.push_back(i);
            if (pbit(ds, dm, i)) dl.push_back(i);
        end
        n = 0;
        for (int k = 0; k < sl.size() && k < dl.size(); k++) begin
            exp_t e;
            int sr, dr;
            sr = sv ? sb + (sl[k] >> ew) : sb;
            dr = dv ? db + (dl[k] >> ew) : db;
            if (sr > 127 || dr > 127) break;
            e.sr  = 7'(sr);
            e.so  = sv ? 3'((sl[k] % (1 << ew)) * (8 >> ew)) : 3'd0;
            e.dr  = 7'(dr);
            e.dof = dv ? 3'((dl[k] % (1 << ew)) * (8 >> ew)) : 3'd0;
            e.c   = (ch && k > 0) ? pat[k-1] : ci;
            q.push_back(e);
            n++;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        vl = 7'd0;
        cyc = 1;
        while (!done) begin
            @(negedge clk);
            cyc++;
            start = (poke_mid && cyc == 2) ? 1'b1 : 1'b0;
        end
        // Same-cycle collision: new launch request while done is high.
        start = 1'b1; vl = 7'd3; src_is_vec = 1'b1; dst_is_vec = 1'b1;
        check({tag, " R3 cycles to done"}, cyc == n + 1, cyc, n + 1);
        check({tag, " R4 all expected issued"}, q.size() == 0, q.size(), 0);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R11 busy low after done"}, busy == 1'b0, busy, 0);
        check({tag, " R1 start in done cycle ignored"},
              done == 1'b0 && issue_valid == 1'b0, issue_valid, 0);
        q.delete();
    endtask

    initial begin
        logic [255:0] crv;
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy == 1'b0, busy, 0);
        check("R11 reset done", done == 1'b0, done, 0);
        check("R1 reset issue", issue_valid == 1'b0, issue_valid, 0);
        rst_n = 1'b1;

        // R2: zero length
        @(negedge clk);
        start = 1'b1; vl = 7'd0;
        @(negedge clk);
        start = 1'b0;
        check("R2 done in cycle after start", done == 1'b1 && issue_valid == 1'b0, done, 1);
        @(negedge clk);
        check("R2 idle afterwards", busy == 1'b0, busy, 0);

        // R3: plain forward vector loop
        run_case("R3 forward", 5, 10, 1, 40, 1, 2'd0, 2'd0, '0, '0, 0, 0, 0, 0, '0, 0);
        // R4/R5: independent integer masks
        run_case("R4 indep masks", 8, 0, 1, 20, 1, 2'd1, 2'd1,
                 64'hB5, 64'h6C, 0, 0, 0, 0, '0, 0);
        // R5: condition-field bit and inverted integer mask
        for (int i = 0; i < 64; i++) crv[4*i +: 4] = 4'(i * 5 + 3);
        cr_fields = crv;
        cr_bit_sel = 2'd2;
        run_case("R5 cr and inverted", 12, 2, 1, 60, 1, 2'd2, 2'd3,
                 '0, 64'h0A5, 0, 0, 0, 0, '0, 0);
        cr_bit_sel = 2'd0;
        run_case("R5 cr bit0", 9, 4, 1, 50, 1, 2'd2, 2'd0,
                 '0, '0, 0, 0, 0, 0, '0, 0);
        // R6: reverse with masks
        run_case("R6 reverse", 10, 30, 1, 70, 1, 2'd1, 2'd3,
                 64'h2D7, 64'h111, 0, 1, 0, 0, '0, 0);
        // R7: packed widths
        run_case("R7 ew8", 20, 5, 1, 90, 1, 2'd0, 2'd0, '0, '0, 3, 0, 0, 0, '0, 0);
        run_case("R7 ew32", 7, 5, 1, 90, 1, 2'd0, 2'd1, '0, 64'h5E, 1, 0, 0, 0, '0, 0);
        run_case("R7 ew16 reverse", 11, 8, 1, 9, 1, 2'd1, 2'd0,
                 64'h7BF, '0, 2, 1, 0, 0, '0, 0);
        // R8: scalar source, vector destination; and the reverse pairing
        run_case("R8 scalar src", 6, 77, 0, 3, 1, 2'd0, 2'd0, '0, '0, 2, 0, 0, 0, '0, 0);
        run_case("R8 scalar dst", 6, 3, 1, 99, 0, 2'd1, 2'd0, 64'h3B, '0, 0, 0, 0, 0, '0, 0);
        // R9: destination runs past the top of the file
        run_case("R9 dst overflow", 8, 0, 1, 125, 1, 2'd0, 2'd0, '0, '0, 0, 0, 0, 0, '0, 0);
        run_case("R9 src overflow ew16", 30, 124, 1, 0, 1, 2'd0, 2'd0, '0, '0, 2, 0, 0, 0, '0, 0);
        // R10: carry chain on and off
        run_case("R10 chain", 9, 0, 1, 16, 1, 2'd0, 2'd0, '0, '0, 0, 0, 1, 1,
                 64'h5A3, 0);
        run_case("R10 no chain", 6, 0, 1, 16, 1, 2'd0, 2'd0, '0, '0, 0, 0, 0, 1,
                 64'h0F0, 0);
        // R1: start pulse mid-loop has no effect
        run_case("R1 start while busy", 7, 1, 1, 33, 1, 2'd1, 2'd0,
                 64'h7F, '0, 0, 0, 1, 0, 64'h2B, 1);
        // R3: length above the cap
        run_case("R3 cap at 64", 100, 0, 1, 0, 1, 2'd0, 2'd0, '0, '0, 3, 0, 0, 0, '0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected loop completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule